// File: doc/BRIEF.md
# Trap Cause and Delegation Unit

This block is the part of a small privileged processor core that decides whether a trap is taken, which privilege level handles it, what cause word is reported, and where the handler starts. It watches six interrupt request lines: software, timer and external, each at machine and at supervisor level. It holds per-interrupt pending and enable bits, an interrupt delegation mask, an exception delegation mask, and one trap-vector register for each of the two handling levels.

Traps go to machine level unless the matching delegation bit routes them to supervisor level. The machine timer and machine external interrupts are wired so that they can never be delegated. When several interrupts are eligible, a fixed priority picks one. A synchronous exception reported by the pipeline wins over any interrupt. All outputs are combinational from the registered state and the current inputs, so the pipeline sees the decision in the same cycle it presents an exception or a privilege change.

Software reaches the registers through a plain port with a write strobe, a small address, write data and combinational read data. Writes take effect at the next rising clock edge.

Top module: `trap_route_unit`

## Requirements
- R1: After reset, every register reads zero and no trap is signalled while no exception is presented.
- R2: The pending register (address 0) holds supervisor software, machine software, supervisor timer, machine timer, supervisor external and machine external at bits 1, 3, 5, 7, 9 and 11, fed by request lines irq_lines_i[0] to irq_lines_i[5] in that order. The machine bits (3, 7, 11) follow their lines and ignore writes. Each supervisor bit (1, 5, 9) reads as its line ORed with a software-written latch. All other bits read zero.
- R3: The enable register (address 1) stores bits 1, 3, 5, 7, 9 and 11 and reads zero elsewhere, so writing all ones reads back 0xAAA.
- R4: The interrupt delegation register (address 2) stores bits 1, 3, 5 and 9 only. Bits 7 and 11 always read zero, so writing all ones reads back 0x22A, and a machine timer or machine external interrupt is never routed to supervisor level.
- R5: For an interrupt, the cause word has its most significant bit set and the interrupt code in the low bits. For an exception, the most significant bit is clear and the low bits hold the exception code.
- R6: Among the eligible interrupts, the one taken is picked in the fixed order machine external (11), machine software (3), machine timer (7), supervisor external (9), supervisor software (1), supervisor timer (5).
- R7: A pending and enabled interrupt is eligible as follows. If it is not delegated, it is eligible when the hart is below machine level, or at machine level with the machine global enable set. If it is delegated, it is eligible at user level, or at supervisor level with the supervisor global enable set, and never at machine level.
- R8: The exception delegation register (address 3) holds one bit per exception code, EXC_N bits wide. A presented exception is always taken, overrides any interrupt, and goes to supervisor level only when its code's bit is set and the hart is not at machine level.
- R9: The machine trap-vector register (address 4) and the supervisor trap-vector register (address 5) keep a 4-byte-aligned base in bits XLEN-1:2, a mode in bit 0 (0 direct, 1 vectored), and bit 1 reads zero. The handler address is the base of the target level's register, except that for an interrupt in vectored mode it is base plus four times the interrupt code.
- R10: Software writing bit 5 of the pending register raises a supervisor timer interrupt (code 5) that is taken like a line-driven one.
- R11: Addresses 6 and 7 read zero and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 6 | Interrupt request lines: S soft, M soft, S timer, M timer, S ext, M ext |
| priv_i | input | 2 | Current hart privilege: 0 user, 1 supervisor, 3 machine |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| exc_valid_i | input | 1 | A synchronous exception is presented this cycle |
| exc_code_i | input | $clog2(EXC_N) | Exception code |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | XLEN | Register write data |
| reg_rdata_o | output | XLEN | Register read data |
| trap_take_o | output | 1 | A trap is taken |
| trap_to_s_o | output | 1 | The trap is handled at supervisor level |
| trap_cause_o | output | XLEN | Cause word |
| trap_vec_o | output | XLEN | Handler address |

## Verification
The bench sweeps every combination of the six request lines against each privilege level, both global enables and two delegation masks, so a priority arbiter with two entries swapped, or an eligibility rule that lets a delegated interrupt fire at machine level, would report a wrong cause or a wrong target level in some corner of the sweep. It writes all ones to each register to catch a delegation bit for the machine timer or machine external line that was left writable, which would let those interrupts leak to supervisor level. Vectored offsets are checked for a low and a high interrupt code, and for an exception, which must still land on the base. Exception-over-interrupt ordering is checked with a machine external interrupt pending at the same time.

// File: rtl/trapdel_pkg.sv
package trapdel_pkg;

   localparam int unsigned IRQ_W  = 12;
   localparam int unsigned NSRC   = 6;

   localparam logic [IRQ_W-1:0] EN_MASK   = 12'hAAA;
   localparam logic [IRQ_W-1:0] IDEL_MASK = 12'h22A;

   localparam logic [3:0] CODE_SSW  = 4'd1;
   localparam logic [3:0] CODE_MSW  = 4'd3;
   localparam logic [3:0] CODE_STMR = 4'd5;
   localparam logic [3:0] CODE_MTMR = 4'd7;
   localparam logic [3:0] CODE_SEXT = 4'd9;
   localparam logic [3:0] CODE_MEXT = 4'd11;

   typedef enum logic [1:0] {
      PRV_U = 2'd0,
      PRV_S = 2'd1,
      PRV_M = 2'd3
   } priv_e;

   typedef enum logic [2:0] {
      RA_PEND = 3'd0,
      RA_EN   = 3'd1,
      RA_IDEL = 3'd2,
      RA_EDEL = 3'd3,
      RA_MVEC = 3'd4,
      RA_SVEC = 3'd5
   } reg_addr_e;

   // Rank 0 is the highest priority.
   function automatic logic [3:0] rank_code(input int unsigned rank);
      case (rank)
         0:       return CODE_MEXT;
         1:       return CODE_MSW;
         2:       return CODE_MTMR;
         3:       return CODE_SEXT;
         4:       return CODE_SSW;
         default: return CODE_STMR;
      endcase
   endfunction

endpackage

// File: rtl/trapdel_regs.sv
module trapdel_regs
   import trapdel_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned EXC_N  = 16,
   parameter bit          VEC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [2:0]        addr_i,
   input  logic [XLEN-1:0]   wdata_i,
   input  logic [NSRC-1:0]   irq_lines_i,
   output logic [IRQ_W-1:0]  pend_o,
   output logic [IRQ_W-1:0]  en_o,
   output logic [IRQ_W-1:0]  ideleg_o,
   output logic [EXC_N-1:0]  edeleg_o,
   output logic [XLEN-1:0]   mvec_o,
   output logic [XLEN-1:0]   svec_o,
   output logic [XLEN-1:0]   rdata_o
);

   localparam logic [XLEN-1:0] MODE_KEEP = XLEN'(VEC_EN ? 1 : 0);
   localparam logic [XLEN-1:0] VEC_KEEP  = ~XLEN'(3) | MODE_KEEP;

   logic wr_pend, wr_en, wr_idel, wr_edel, wr_mvec, wr_svec;

   assign wr_pend = we_i && (addr_i == RA_PEND);
   assign wr_en   = we_i && (addr_i == RA_EN);
   assign wr_idel = we_i && (addr_i == RA_IDEL);
   assign wr_edel = we_i && (addr_i == RA_EDEL);
   assign wr_mvec = we_i && (addr_i == RA_MVEC);
   assign wr_svec = we_i && (addr_i == RA_SVEC);

   // Pending bits: supervisor sources carry a software latch, machine
   // sources are a straight view of their request line.
   genvar k;
   generate
      for (k = 0; k < NSRC; k++) begin : g_src
         localparam int unsigned CBIT = 2 * k + 1;
         assign pend_o[2*k] = 1'b0;
         if ((k % 2) == 0) begin : g_sup
            logic soft_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)       soft_q <= 1'b0;
               else if (wr_pend) soft_q <= wdata_i[CBIT];
            end
            assign pend_o[CBIT] = irq_lines_i[k] | soft_q;
         end else begin : g_mach
            assign pend_o[CBIT] = irq_lines_i[k];
         end
      end
   endgenerate

   logic [IRQ_W-1:0] en_q, idel_q;
   logic [EXC_N-1:0] edel_q;
   logic [XLEN-1:0]  mvec_q, svec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         idel_q <= '0;
         edel_q <= '0;
         mvec_q <= '0;
         svec_q <= '0;
      end else begin
         if (wr_en)   en_q   <= wdata_i[IRQ_W-1:0] & EN_MASK;
         if (wr_idel) idel_q <= wdata_i[IRQ_W-1:0] & IDEL_MASK;
         if (wr_edel) edel_q <= wdata_i[EXC_N-1:0];
         if (wr_mvec) mvec_q <= wdata_i & VEC_KEEP;
         if (wr_svec) svec_q <= wdata_i & VEC_KEEP;
      end
   end

   assign en_o     = en_q;
   assign ideleg_o = idel_q;
   assign edeleg_o = edel_q;
   assign mvec_o   = mvec_q;
   assign svec_o   = svec_q;

   always_comb begin
      case (addr_i)
         RA_PEND: rdata_o = XLEN'(pend_o);
         RA_EN:   rdata_o = XLEN'(en_q);
         RA_IDEL: rdata_o = XLEN'(idel_q);
         RA_EDEL: rdata_o = XLEN'(edel_q);
         RA_MVEC: rdata_o = mvec_q;
         RA_SVEC: rdata_o = svec_q;
         default: rdata_o = '0;
      endcase
   end

   // R10: a software write to the supervisor timer bit shows up next cycle
   assert_soft_stmr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pend && wdata_i[CODE_STMR]) |=> pend_o[CODE_STMR]);

   // R3: the enable register keeps exactly the written interrupt bits
   assert_en_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (en_o == ($past(wdata_i[IRQ_W-1:0]) & EN_MASK)));

   // R11: unmapped writes leave the enable and delegation state alone
   assert_unmapped_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && addr_i[2] && addr_i[1]) |=> ($stable(en_o) && $stable(ideleg_o) && $stable(edeleg_o)));

endmodule

// File: rtl/trapdel_irq_sel.sv
module trapdel_irq_sel
   import trapdel_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IRQ_W-1:0]  pend_i,
   input  logic [IRQ_W-1:0]  en_i,
   input  logic [IRQ_W-1:0]  ideleg_i,
   input  logic [1:0]        priv_i,
   input  logic              m_gie_i,
   input  logic              s_gie_i,
   output logic              irq_valid_o,
   output logic [3:0]        irq_code_o,
   output logic              irq_to_s_o
);

   logic s_ok, m_ok;
   logic [NSRC-1:0] eligible;

   assign s_ok = (priv_i == PRV_U) || ((priv_i == PRV_S) && s_gie_i);
   assign m_ok = (priv_i != PRV_M) || m_gie_i;

   genvar k;
   generate
      for (k = 0; k < NSRC; k++) begin : g_elig
         localparam int unsigned CBIT = 2 * k + 1;
         logic armed;
         assign armed       = pend_i[CBIT] && en_i[CBIT];
         assign eligible[k] = armed && (ideleg_i[CBIT] ? s_ok : m_ok);
      end
   endgenerate

   // Walk from the lowest rank upward so the highest eligible rank wins.
   always_comb begin
      irq_valid_o = 1'b0;
      irq_code_o  = 4'd0;
      irq_to_s_o  = 1'b0;
      for (int r = NSRC - 1; r >= 0; r--) begin
         logic [3:0] c;
         c = rank_code(r);
         if (eligible[c[3:1]]) begin
            irq_valid_o = 1'b1;
            irq_code_o  = c;
            irq_to_s_o  = ideleg_i[c];
         end
      end
   end

   // R7: nothing is routed to supervisor level while the hart runs at machine level
   assert_no_s_at_m_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid_o && irq_to_s_o) |-> (priv_i != PRV_M));

   // R4: machine timer and machine external always stay at machine level
   assert_mlocked_stay_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid_o && ((irq_code_o == CODE_MTMR) || (irq_code_o == CODE_MEXT))) |-> !irq_to_s_o);

   // R6: the chosen interrupt is pending and enabled
   assert_pick_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid_o |-> (pend_i[irq_code_o] && en_i[irq_code_o]));

endmodule

// File: rtl/trapdel_vec.sv
module trapdel_vec #(
   parameter int unsigned XLEN = 32
) (
   input  logic [XLEN-1:0] vec_reg_i,
   input  logic            is_irq_i,
   input  logic [3:0]      code_i,
   output logic [XLEN-1:0] addr_o
);

   logic [XLEN-1:0] base;
   logic            use_offset;

   assign base       = {vec_reg_i[XLEN-1:2], 2'b00};
   assign use_offset = vec_reg_i[0] && is_irq_i;
   assign addr_o     = use_offset ? (base + XLEN'({code_i, 2'b00})) : base;

endmodule

// File: rtl/trap_route_unit.sv
module trap_route_unit
   import trapdel_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned EXC_N  = 16,
   parameter bit          VEC_EN = 1'b1,
   localparam int unsigned EXC_W = $clog2(EXC_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [5:0]        irq_lines_i,
   input  logic [1:0]        priv_i,
   input  logic              m_gie_i,
   input  logic              s_gie_i,
   input  logic              exc_valid_i,
   input  logic [EXC_W-1:0]  exc_code_i,
   input  logic              reg_we_i,
   input  logic [2:0]        reg_addr_i,
   input  logic [XLEN-1:0]   reg_wdata_i,
   output logic [XLEN-1:0]   reg_rdata_o,
   output logic              trap_take_o,
   output logic              trap_to_s_o,
   output logic [XLEN-1:0]   trap_cause_o,
   output logic [XLEN-1:0]   trap_vec_o
);

   generate
      if (!((XLEN == 32) || (XLEN == 64))) begin : g_bad_xlen
         $error("trap_route_unit: XLEN must be 32 or 64");
      end
      if ((EXC_N < 2) || (EXC_N >= XLEN) || ((1 << EXC_W) != EXC_N)) begin : g_bad_excn
         $error("trap_route_unit: EXC_N must be a power of two below XLEN");
      end
   endgenerate

   logic [IRQ_W-1:0] pend, en, ideleg;
   logic [EXC_N-1:0] edeleg;
   logic [XLEN-1:0]  mvec, svec;

   trapdel_regs #(.XLEN(XLEN), .EXC_N(EXC_N), .VEC_EN(VEC_EN)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .we_i        (reg_we_i),
      .addr_i      (reg_addr_i),
      .wdata_i     (reg_wdata_i),
      .irq_lines_i (irq_lines_i),
      .pend_o      (pend),
      .en_o        (en),
      .ideleg_o    (ideleg),
      .edeleg_o    (edeleg),
      .mvec_o      (mvec),
      .svec_o      (svec),
      .rdata_o     (reg_rdata_o)
   );

   logic       irq_valid, irq_to_s;
   logic [3:0] irq_code;

   trapdel_irq_sel u_sel (
      .clk         (clk),
      .rst_n       (rst_n),
      .pend_i      (pend),
      .en_i        (en),
      .ideleg_i    (ideleg),
      .priv_i      (priv_i),
      .m_gie_i     (m_gie_i),
      .s_gie_i     (s_gie_i),
      .irq_valid_o (irq_valid),
      .irq_code_o  (irq_code),
      .irq_to_s_o  (irq_to_s)
   );

   logic            exc_to_s, is_irq;
   logic [XLEN-1:0] irq_cause, exc_cause, sel_vec;

   assign exc_to_s  = edeleg[exc_code_i] && (priv_i != PRV_M);
   assign is_irq    = irq_valid && !exc_valid_i;
   assign irq_cause = {1'b1, {(XLEN-1){1'b0}}} | XLEN'(irq_code);
   assign exc_cause = XLEN'(exc_code_i);

   assign trap_take_o  = exc_valid_i || irq_valid;
   assign trap_to_s_o  = exc_valid_i ? exc_to_s : (irq_valid && irq_to_s);
   assign trap_cause_o = exc_valid_i ? exc_cause : (irq_valid ? irq_cause : '0);
   assign sel_vec      = trap_to_s_o ? svec : mvec;

   trapdel_vec #(.XLEN(XLEN)) u_vec (
      .vec_reg_i (sel_vec),
      .is_irq_i  (is_irq),
      .code_i    (irq_code),
      .addr_o    (trap_vec_o)
   );

   // R5: interrupts report the top bit set, exceptions report it clear
   assert_irq_cause_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_take_o && !exc_valid_i) |-> trap_cause_o[XLEN-1]);
   assert_exc_cause_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid_i |-> (trap_take_o && !trap_cause_o[XLEN-1]));

   // R8: an exception never goes to supervisor level from machine level
   assert_exc_stay_m_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid_i && (priv_i == PRV_M)) |-> !trap_to_s_o);

   // R9: handler addresses are word aligned
   assert_vec_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_take_o |-> (trap_vec_o[1:0] == 2'b00));

endmodule

// File: tb/tb_trap_route_unit.sv
module tb_trap_route_unit;

   localparam int unsigned XLEN  = 32;
   localparam int unsigned EXC_N = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [5:0]        irq_lines = '0;
   logic [1:0]        priv = 2'd3;
   logic              m_gie = 1'b0;
   logic              s_gie = 1'b0;
   logic              exc_valid = 1'b0;
   logic [3:0]        exc_code = '0;
   logic              reg_we = 1'b0;
   logic [2:0]        reg_addr = '0;
   logic [XLEN-1:0]   reg_wdata = '0;
   logic [XLEN-1:0]   reg_rdata;
   logic              trap_take, trap_to_s;
   logic [XLEN-1:0]   trap_cause, trap_vec;

   int n_checks = 0;
   int n_fails  = 0;

   always #2.5 clk = ~clk;

   trap_route_unit #(.XLEN(XLEN), .EXC_N(EXC_N), .VEC_EN(1'b1)) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .irq_lines_i  (irq_lines),
      .priv_i       (priv),
      .m_gie_i      (m_gie),
      .s_gie_i      (s_gie),
      .exc_valid_i  (exc_valid),
      .exc_code_i   (exc_code),
      .reg_we_i     (reg_we),
      .reg_addr_i   (reg_addr),
      .reg_wdata_i  (reg_wdata),
      .reg_rdata_o  (reg_rdata),
      .trap_take_o  (trap_take),
      .trap_to_s_o  (trap_to_s),
      .trap_cause_o (trap_cause),
      .trap_vec_o   (trap_vec)
   );

   task automatic check(input string req, input string what,
                        input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [XLEN-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [XLEN-1:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   // Ordered list from the priority requirement.
   function automatic int code_at(input int r);
      case (r)
         0: return 11; 1: return 3; 2: return 7;
         3: return 9;  4: return 1; default: return 5;
      endcase
   endfunction

   // Returns the expected interrupt code, or -1; sets exp_s for the target.
   function automatic int expect_irq(input logic [11:0] pend, input logic [11:0] en,
                                     input logic [11:0] idel, input logic [1:0] p,
                                     input logic mg, input logic sg, output logic exp_s);
      exp_s = 1'b0;
      for (int r = 0; r < 6; r++) begin
         int c;
         logic ok;
         c = code_at(r);
         if (pend[c] && en[c]) begin
            if (idel[c]) ok = (p == 2'd0) || ((p == 2'd1) && sg);
            else         ok = (p != 2'd3) || mg;
            if (ok) begin
               exp_s = idel[c];
               return c;
            end
         end
      end
      return -1;
   endfunction

   initial begin : watchdog
      #(200000 * 5);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin : main
      logic [XLEN-1:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d);
         check("R1", $sformatf("reg %0d after reset", a), d, '0);
      end
      check("R1", "no trap after reset", {31'd0, trap_take}, 32'd0);

      // R3, R4, R8, R9: masked register images
      wr(3'd1, '1); rd(3'd1, d); check("R3", "enable all ones", d, 32'hAAA);
      wr(3'd2, '1); rd(3'd2, d); check("R4", "ideleg all ones", d, 32'h22A);
      wr(3'd3, '1); rd(3'd3, d); check("R8", "edeleg all ones", d, 32'hFFFF);
      wr(3'd4, '1); rd(3'd4, d); check("R9", "mvec all ones", d, 32'hFFFF_FFFD);
      wr(3'd5, 32'h0000_2003); rd(3'd5, d); check("R9", "svec mode bit1", d, 32'h2001);

      // R11: unmapped addresses
      wr(3'd6, '1); rd(3'd6, d); check("R11", "addr 6 reads zero", d, '0);
      wr(3'd7, '1); rd(3'd7, d); check("R11", "addr 7 reads zero", d, '0);
      rd(3'd1, d); check("R11", "enable untouched", d, 32'hAAA);
      rd(3'd3, d); check("R11", "edeleg untouched", d, 32'hFFFF);

      // R2: pending writes reach only supervisor bits; lines show through
      wr(3'd0, 32'hFFF); rd(3'd0, d); check("R2", "pending write all", d, 32'h222);
      wr(3'd0, 32'h0);   rd(3'd0, d); check("R2", "pending cleared", d, 32'h0);
      irq_lines = 6'b101010; rd(3'd0, d); check("R2", "machine lines", d, 32'h888);
      irq_lines = 6'b010101; rd(3'd0, d); check("R2", "supervisor lines", d, 32'h222);
      irq_lines = '0;

      // R4: machine timer cannot be delegated even with ideleg all ones
      wr(3'd2, '1);
      priv = 2'd0; irq_lines = 6'b001000; #1;
      check("R4", "mtimer cause", trap_cause, 32'h8000_0007);
      check("R4", "mtimer stays at M", {31'd0, trap_to_s}, 32'd0);
      irq_lines = 6'b100000; #1;
      check("R4", "mext stays at M", {31'd0, trap_to_s}, 32'd0);
      irq_lines = '0;

      // R5 R6 R7: sweep lines x privilege x global enables x delegation
      wr(3'd4, 32'h0000_1000);
      wr(3'd5, 32'h0000_2000);
      for (int dsel = 0; dsel < 2; dsel++) begin
         logic [11:0] idel;
         idel = (dsel == 0) ? 12'h000 : 12'h22A;
         wr(3'd2, 32'(idel));
         for (int pi = 0; pi < 3; pi++) begin
            for (int g = 0; g < 4; g++) begin
               for (int v = 0; v < 64; v++) begin
                  logic [11:0] pend;
                  logic exp_s;
                  int c;
                  priv = (pi == 2) ? 2'd3 : 2'(pi);
                  m_gie = g[0]; s_gie = g[1];
                  irq_lines = 6'(v);
                  pend = '0;
                  for (int k = 0; k < 6; k++) pend[2*k+1] = v[k];
                  c = expect_irq(pend, 12'hAAA, idel, priv, m_gie, s_gie, exp_s);
                  #1;
                  if (c < 0) begin
                     check("R7", "no trap expected", {31'd0, trap_take}, 32'd0);
                  end else begin
                     check("R6", $sformatf("pick v=%0h p=%0d g=%0d", v, priv, g),
                           trap_cause, 32'h8000_0000 | 32'(c));
                     check("R7", "target level", {31'd0, trap_to_s}, {31'd0, exp_s});
                     check("R9", "direct vector", trap_vec,
                           exp_s ? 32'h2000 : 32'h1000);
                  end
                  @(negedge clk);
               end
            end
         end
      end
      irq_lines = '0; m_gie = 1'b0; s_gie = 1'b0;

      // R10: software-set supervisor timer pending, delegated, user level
      wr(3'd2, 32'h22A);
      priv = 2'd0;
      wr(3'd0, 32'h20);
      #1;
      check("R10", "soft stimer taken", {31'd0, trap_take}, 32'd1);
      check("R10", "soft stimer cause", trap_cause, 32'h8000_0005);
      check("R10", "soft stimer to S", {31'd0, trap_to_s}, 32'd1);

      // R9: vectored offsets
      wr(3'd5, 32'h0000_2001);
      #1;
      check("R9", "vectored stimer", trap_vec, 32'h2014);
      wr(3'd0, 32'h0);
      wr(3'd4, 32'h0000_1001);
      irq_lines = 6'b100000; #1;
      check("R9", "vectored mext", trap_vec, 32'h102C);

      // R8: exceptions override interrupts and follow their own mask
      wr(3'd3, 32'h0004);
      priv = 2'd1; m_gie = 1'b1;
      exc_valid = 1'b1; exc_code = 4'd2; #1;
      check("R8", "exc cause over irq", trap_cause, 32'h2);
      check("R8", "delegated exc to S", {31'd0, trap_to_s}, 32'd1);
      check("R9", "exc ignores vectored offset", trap_vec, 32'h2000);
      priv = 2'd3; #1;
      check("R8", "exc at M stays at M", {31'd0, trap_to_s}, 32'd0);
      check("R8", "exc at M vector", trap_vec, 32'h1000);
      priv = 2'd0; exc_code = 4'd3; #1;
      check("R8", "undelegated exc to M", {31'd0, trap_to_s}, 32'd0);
      check("R5", "exc cause top bit clear", trap_cause, 32'h3);
      exc_valid = 1'b0; irq_lines = '0;
      @(negedge clk);

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule